// File: doc/BRIEF.md
# Security-Filtered Peripheral Clock Enable Register

This block holds one 32-bit memory-mapped register whose implemented bits turn peripheral clocks on and off. Eleven bits are implemented: four IO-port enables, enables for an AES engine, a hash engine, a random number generator, a second AES engine, a hardware semaphore unit, a public-key engine and a second SRAM bank. Each implemented bit drives a bus clock enable output. The random number generator bit also drives a separate kernel clock enable.

Every register access carries two flags: secure and privileged. Each bit also has its own secure attribute, supplied from outside. Two lock inputs set the privilege rules. One lock applies to bits marked secure, the other to bits marked non-secure. Together these inputs form an allow mask for each access, one decision per bit. A bit that is not allowed reads as zero and ignores writes. No fault or error is ever reported.

Top module: `sec_clk_enable_reg`

## Requirements
- R1: After reset, every bit of `bus_ce` and `rng_kernel_ce` is 0.
- R2: A write whose access is allowed for a bit loads that bit from `req_wdata`, so both 1 and 0 stick. The new value appears on `bus_ce` after the next rising clock edge. A bit that is not allowed keeps its value.
- R3: When a bit's effective secure attribute is 1, a non-secure access reads 0 in that bit and a non-secure write leaves the bit unchanged.
- R4: When `lock_priv_sec` is 1, an unprivileged access can neither read nor write any bit whose effective secure attribute is 1.
- R5: When `lock_priv_nsec` is 1, an unprivileged access can neither read nor write any bit whose effective secure attribute is 0. This holds whether the access is secure or non-secure.
- R6: A secure access can reach both secure and non-secure bits. The only limit is the privilege rule that matches each bit's own attribute.
- R7: Only bits 0, 1, 2, 7, 16, 17, 18, 19, 20, 21 and 30 are implemented. All other bits read 0 and ignore writes.
- R8: `rng_kernel_ce` always equals `bus_ce[18]`, the random number generator bit. It is held in its own flip-flop.
- R9: The effective secure attribute of bit 20, the semaphore bit, is the OR of `sema_feat_secure`. The value of `bit_secure[20]` is ignored. Every other bit uses its own `bit_secure` input.
- R10: `rsp_rdata` is combinational and valid in the same cycle as a read at `REG_ADDR`. It equals the register value ANDed with the allow mask. In any other cycle it is 0.
- R11: A write to an address other than `REG_ADDR` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | 32 | Write data |
| req_secure | input | 1 | Access comes from the secure world |
| req_priv | input | 1 | Access is privileged |
| rsp_rdata | output | 32 | Read data, returned in the same cycle |
| bit_secure | input | 32 | Per-bit secure attribute |
| sema_feat_secure | input | SEM_FEATS | Secure flags of the semaphore unit's features |
| lock_priv_sec | input | 1 | Blocks unprivileged access to secure bits |
| lock_priv_nsec | input | 1 | Blocks unprivileged access to non-secure bits |
| bus_ce | output | 32 | Registered bus clock enables |
| rng_kernel_ce | output | 1 | Registered kernel clock enable of the random number generator |

## Verification
The bench builds the block with `SEM_FEATS` = 2 and a non-default `REG_ADDR`. With two feature flags, the sweep can reach the cases where only one of the semaphore flags is set, so the OR in R9 is exercised in both directions. The sweep also covers both settings of the bus address decode. It walks all sixteen combinations of access security, access privilege and the two locks. Each combination runs against four attribute patterns. In those patterns every implemented bit is secure in some cases and non-secure in others.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int REG_W = 32;

  localparam int POS_IOA   = 0;
  localparam int POS_IOB   = 1;
  localparam int POS_IOC   = 2;
  localparam int POS_IOH   = 7;
  localparam int POS_AES   = 16;
  localparam int POS_HASH  = 17;
  localparam int POS_RNG   = 18;
  localparam int POS_AES2  = 19;
  localparam int POS_SEMA  = 20;
  localparam int POS_PKEY  = 21;
  localparam int POS_SRAM2 = 30;

  localparam logic [REG_W-1:0] IMPL_MASK =
      (REG_W'(1) << POS_IOA)  | (REG_W'(1) << POS_IOB)  | (REG_W'(1) << POS_IOC) |
      (REG_W'(1) << POS_IOH)  | (REG_W'(1) << POS_AES)  | (REG_W'(1) << POS_HASH) |
      (REG_W'(1) << POS_RNG)  | (REG_W'(1) << POS_AES2) | (REG_W'(1) << POS_SEMA) |
      (REG_W'(1) << POS_PKEY) | (REG_W'(1) << POS_SRAM2);

  typedef struct packed {
    logic secure;
    logic priv;
  } scr_attr_t;
endpackage

// File: rtl/scr_attr_merge.sv
module scr_attr_merge #(
  parameter int SEM_FEATS = 3
) (
  input  logic [scr_pkg::REG_W-1:0] bit_secure,
  input  logic [SEM_FEATS-1:0]      sema_feat_secure,
  output logic [scr_pkg::REG_W-1:0] eff_secure
);
  import scr_pkg::*;

  always_comb begin
    eff_secure           = bit_secure & IMPL_MASK;
    eff_secure[POS_SEMA] = |sema_feat_secure;
  end
endmodule

// File: rtl/scr_access_filter.sv
module scr_access_filter (
  input  scr_pkg::scr_attr_t        acc,
  input  logic [scr_pkg::REG_W-1:0] eff_secure,
  input  logic                      lock_priv_sec,
  input  logic                      lock_priv_nsec,
  output logic [scr_pkg::REG_W-1:0] allow
);
  import scr_pkg::*;

  localparam int W = REG_W;

  // One access decision per implemented bit; reserved bits are never allowed.
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      logic world_ok;
      logic priv_ok;
      always_comb begin
        world_ok = acc.secure | ~eff_secure[i];
        priv_ok  = eff_secure[i] ? (~lock_priv_sec | acc.priv)
                                 : (~lock_priv_nsec | acc.priv);
        allow[i] = world_ok & priv_ok;
      end
    end else begin : g_rsvd
      assign allow[i] = 1'b0;
    end
  end
endmodule

// File: rtl/scr_enable_bank.sv
module scr_enable_bank (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [scr_pkg::REG_W-1:0] wdata,
  input  logic [scr_pkg::REG_W-1:0] allow,
  output logic [scr_pkg::REG_W-1:0] q,
  output logic                      kern_q
);
  import scr_pkg::*;

  localparam int W = REG_W;

  for (genvar i = 0; i < W; i++) begin : g_ff
    if (IMPL_MASK[i]) begin : g_impl
      always_ff @(posedge clk) begin
        if (rst)                   q[i] <= 1'b0;
        else if (wr_en && allow[i]) q[i] <= wdata[i];
      end
    end else begin : g_rsvd
      assign q[i] = 1'b0;
    end
  end

  // Kernel clock enable kept in its own flop, loaded under the same condition.
  always_ff @(posedge clk) begin
    if (rst)                        kern_q <= 1'b0;
    else if (wr_en && allow[POS_RNG]) kern_q <= wdata[POS_RNG];
  end
endmodule

// File: rtl/sec_clk_enable_reg.sv
module sec_clk_enable_reg #(
  parameter int               ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h4C,
  parameter int               SEM_FEATS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [31:0]          req_wdata,
  input  logic                 req_secure,
  input  logic                 req_priv,
  output logic [31:0]          rsp_rdata,
  input  logic [31:0]          bit_secure,
  input  logic [SEM_FEATS-1:0] sema_feat_secure,
  input  logic                 lock_priv_sec,
  input  logic                 lock_priv_nsec,
  output logic [31:0]          bus_ce,
  output logic                 rng_kernel_ce
);
  import scr_pkg::*;

  logic             hit;
  logic             wr_en;
  logic             rd_en;
  scr_attr_t        acc;
  logic [REG_W-1:0] eff_secure;
  logic [REG_W-1:0] allow;
  logic [REG_W-1:0] q;

  assign hit        = req_valid && (req_addr == REG_ADDR);
  assign wr_en      = hit && req_write;
  assign rd_en      = hit && !req_write;
  assign acc.secure = req_secure;
  assign acc.priv   = req_priv;

  scr_attr_merge #(.SEM_FEATS(SEM_FEATS)) u_merge (
    .bit_secure       (bit_secure),
    .sema_feat_secure (sema_feat_secure),
    .eff_secure       (eff_secure)
  );

  scr_access_filter u_filt (
    .acc            (acc),
    .eff_secure     (eff_secure),
    .lock_priv_sec  (lock_priv_sec),
    .lock_priv_nsec (lock_priv_nsec),
    .allow          (allow)
  );

  scr_enable_bank u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wdata  (req_wdata),
    .allow  (allow),
    .q      (q),
    .kern_q (rng_kernel_ce)
  );

  assign rsp_rdata = rd_en ? (q & allow) : '0;
  assign bus_ce    = q;
endmodule

// File: rtl/sec_clk_enable_reg_chk.sv
module sec_clk_enable_reg_chk #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h4C,
  parameter int                SEM_FEATS = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [ADDR_W-1:0]    req_addr,
  input logic                 req_secure,
  input logic                 req_priv,
  input logic [31:0]          rsp_rdata,
  input logic [31:0]          bit_secure,
  input logic [SEM_FEATS-1:0] sema_feat_secure,
  input logic                 lock_priv_sec,
  input logic                 lock_priv_nsec,
  input logic [31:0]          bus_ce,
  input logic                 rng_kernel_ce
);
  logic [31:0] secm;
  logic        wr_hit;
  always_comb begin
    secm     = bit_secure;
    secm[20] = |sema_feat_secure;
    wr_hit   = req_valid && req_write && (req_addr == REG_ADDR);
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (bus_ce == 32'h0 && !rng_kernel_ce));

  p_idle_stable_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(bus_ce));

  p_ns_read_hidden_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !req_secure) |-> ((rsp_rdata & secm) == 32'h0));

  p_ns_write_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !req_secure) |=> ((bus_ce & $past(secm)) == ($past(bus_ce) & $past(secm))));

  p_sec_lock_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !req_priv && lock_priv_sec) |=> ((bus_ce & $past(secm)) == ($past(bus_ce) & $past(secm))));

  p_nsec_lock_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !req_priv && lock_priv_nsec) |=> ((bus_ce & ~$past(secm)) == ($past(bus_ce) & ~$past(secm))));

  p_kernel_match_r8: assert property (@(posedge clk) disable iff (rst)
    rng_kernel_ce == bus_ce[18]);

  p_rdata_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |-> (rsp_rdata == 32'h0));
endmodule

bind sec_clk_enable_reg sec_clk_enable_reg_chk #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .SEM_FEATS(SEM_FEATS)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_secure(req_secure), .req_priv(req_priv),
  .rsp_rdata(rsp_rdata), .bit_secure(bit_secure),
  .sema_feat_secure(sema_feat_secure), .lock_priv_sec(lock_priv_sec),
  .lock_priv_nsec(lock_priv_nsec), .bus_ce(bus_ce), .rng_kernel_ce(rng_kernel_ce)
);

// File: tb/sim_sec_clk_enable_reg.sv
module sim_sec_clk_enable_reg;
  localparam int         ADDR_W    = 8;
  localparam logic [7:0] REG_ADDR  = 8'h90;
  localparam int         SEM_FEATS = 2;
  localparam logic [31:0] IMPL = 32'h403F_0087;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0, req_priv = 1'b0;
  logic [7:0]  req_addr = 8'h0;
  logic [31:0] req_wdata = 32'h0;
  logic [31:0] bit_secure = 32'h0;
  logic [SEM_FEATS-1:0] sema_feat_secure = '0;
  logic lock_priv_sec = 1'b0, lock_priv_nsec = 1'b0;
  logic [31:0] rsp_rdata, bus_ce;
  logic rng_kernel_ce;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] model_q = 32'h0;

  always #10 clk = ~clk;

  sec_clk_enable_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .SEM_FEATS(SEM_FEATS)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_secure(req_secure),
    .req_priv(req_priv), .rsp_rdata(rsp_rdata), .bit_secure(bit_secure),
    .sema_feat_secure(sema_feat_secure), .lock_priv_sec(lock_priv_sec),
    .lock_priv_nsec(lock_priv_nsec), .bus_ce(bus_ce), .rng_kernel_ce(rng_kernel_ce)
  );

  // Reference permission rule written per bit from the requirements.
  function automatic logic [31:0] ref_allow();
    logic [31:0] m = 32'h0;
    for (int i = 0; i < 32; i++) begin
      logic s;
      bit ok;
      s = (i == 20) ? |sema_feat_secure : bit_secure[i];
      ok = IMPL[i];
      if (s && !req_secure) ok = 0;
      if (s && lock_priv_sec && !req_priv) ok = 0;
      if (!s && lock_priv_nsec && !req_priv) ok = 0;
      m[i] = ok;
    end
    return m;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) model_q <= 32'h0;
    else if (req_valid && req_write && req_addr == REG_ADDR) begin
      logic [31:0] a;
      a = ref_allow();
      model_q <= (model_q & ~a) | (req_wdata & a);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R2 bus_ce", bus_ce, model_q);
      check("R8 kernel", {31'h0, rng_kernel_ce}, {31'h0, model_q[18]});
    end
  end

  task automatic access(string tag, bit w, bit s, bit p, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_secure = s; req_priv = p;
    req_addr = a; req_wdata = d;
    #2;
    if (!w && a == REG_ADDR) check(tag, rsp_rdata, model_q & ref_allow());
    else check({tag, " R10 idle rdata"}, rsp_rdata, 32'h0);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  function automatic string tag_for(bit s, bit p, bit ls, bit ln);
    if (!p && ls) return "R4";
    if (!p && ln) return "R5";
    if (!s) return "R3";
    return "R6";
  endfunction

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h0; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h5A95_00A5; pats[3] = 32'hA56A_FF5A;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset bus_ce", bus_ce, 32'h0);
    check("R1 reset kernel", {31'h0, rng_kernel_ce}, 32'h0);
    @(negedge clk); rst = 0;

    // R7: full write from the most permissive access, reserved bits stay 0
    access("R7", 1, 1, 1, REG_ADDR, 32'hFFFF_FFFF);
    idle();
    check("R7 reserved", bus_ce & ~IMPL, 32'h0);
    check("R2 set all", bus_ce, IMPL);
    // R11: other address ignored
    access("R11", 1, 1, 1, REG_ADDR + 8'h4, 32'h0);
    idle();
    check("R11 other addr", bus_ce, IMPL);
    // R2 clear, R8 kernel follows
    access("R2", 1, 1, 1, REG_ADDR, 32'h0004_0000);
    idle();
    check("R8 kernel set", {31'h0, rng_kernel_ce}, 32'h1);
    check("R2 clear", bus_ce, 32'h0004_0000);
    // R9: semaphore bit secure from one feature flag only
    bit_secure = 32'h0010_0000; sema_feat_secure = 2'b00;
    access("R9", 1, 0, 1, REG_ADDR, 32'h0010_0000);
    idle();
    check("R9 attr ignored", bus_ce[20] ? 32'h1 : 32'h0, 32'h1);
    sema_feat_secure = 2'b10;
    access("R9", 1, 0, 1, REG_ADDR, 32'h0);
    access("R9", 0, 0, 1, REG_ADDR, 32'h0);
    idle();
    check("R9 feature secure", bus_ce[20] ? 32'h1 : 32'h0, 32'h1);

    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 4; k++) begin
        bit s, p, ls, ln;
        string t;
        s = c[0]; p = c[1]; ls = c[2]; ln = c[3];
        t = tag_for(s, p, ls, ln);
        bit_secure = pats[k]; sema_feat_secure = k[1:0];
        lock_priv_sec = ls; lock_priv_nsec = ln;
        access(t, 1, s, p, REG_ADDR, 32'hFFFF_FFFF);
        access(t, 0, s, p, REG_ADDR, 32'h0);
        access(t, 1, s, p, REG_ADDR, 32'h5555_AAAA ^ pats[k]);
        access(t, 0, s, p, REG_ADDR, 32'h0);
        access("R11", 1, s, p, REG_ADDR ^ 8'h01, 32'h0);
        access(t, 1, 1, 1, REG_ADDR, {pats[(k + 1) % 4][15:0], pats[k][31:16]});
      end
    end
    idle();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule